// File: doc/BRIEF.md
# Banked Effective Address Generator

This block forms the 24-bit bus address for one memory access of an 8/16-bit processor core. The sequencer gives it an addressing-mode code, up to three operand bytes, the two index registers, the direct page base, the data and program bank bytes, the program counter and the current processor mode flags. One clock later the block returns the address of the first byte and the address of the following byte, which a 16-bit access uses. It also returns two cost flags that the bus timing logic adds to its cycle count.

Most addresses are a bank byte placed above a 16-bit offset. Data uses the data bank and code uses the program bank. Long operands supply all 24 bits themselves. Direct page addresses and jump pointers always fall in bank zero. The direct page base can move anywhere in bank zero, and a base that does not start on a 256-byte boundary costs one penalty cycle. In emulation mode with an aligned base, direct page indexing stays inside its 256-byte page. Each request is captured when `req_valid` is high, and the results stay on the outputs until the next request.

Top module: `bank_ea_gen`

## Requirements
- R1: While `rst_n` is low, every output is zero. `ea_valid` is high in exactly the cycle after a cycle with `req_valid` high. When `req_valid` is low, the address outputs and flags keep their last values.
- R2: Mode 0 (absolute) gives `{dbr, opnd[15:0]}`. The unused code 7 behaves exactly like mode 0.
- R3: Mode 1 (absolute indexed) gives `{dbr, opnd[15:0]}` plus the index as a 24-bit sum. A carry out of the offset increments the bank byte.
- R4: `idx_sel` = 0 selects X and 1 selects Y. When `emu` = 1 or `xflag` = 1, only the low 8 bits of the selected register are used and the upper 8 bits are treated as zero. Otherwise all 16 bits are used.
- R5: Mode 2 (long) gives `opnd[23:0]` unchanged, ignoring both bank bytes.
- R6: Mode 3 (direct) gives `{8'h00, (dpr + opnd[7:0]) mod 2^16}`.
- R7: Mode 4 (direct indexed) gives `{8'h00, (dpr + opnd[7:0] + index) mod 2^16}`, except in the case covered by R8.
- R8: In mode 4, when `emu` = 1 and `dpr[7:0]` = 0, the result is `{8'h00, dpr[15:8], (opnd[7:0] + index[7:0]) mod 256}`.
- R9: `extra_cyc` is 1 only for modes 3 and 4 when `dpr[7:0]` is nonzero. It is 0 in every other case.
- R10: Mode 5 (program fetch) gives `{pbr, pc}`. The second-byte address is `{pbr, (pc + 1) mod 2^16}`.
- R11: Mode 6 (jump pointer) gives `{8'h00, opnd[15:0]}`, ignoring `dbr` and `pbr`.
- R12: `wide` is 1 when `emu` = 0 and `mflag` = 0 for modes 0, 1, 2, 3, 4 and 7. It is 0 for modes 5 and 6, and 0 whenever `emu` = 1.
- R13: `ea_hi` is the address of the following byte, formed as follows:
  - modes 0, 1, 2 and 7: `ea` + 1 as a 24-bit sum;
  - modes 3, 4 and 6: the 16-bit offset + 1 with wraparound, bank unchanged;
  - the R8 case: it wraps within the 256-byte page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Capture a new address request |
| mode | input | 3 | Addressing-mode code (see R2 to R11) |
| opnd | input | 24 | Operand bytes, low byte first |
| idx_sel | input | 1 | Index select: 0 = X, 1 = Y |
| x_reg | input | 16 | X index register |
| y_reg | input | 16 | Y index register |
| dpr | input | 16 | Direct page base |
| dbr | input | 8 | Data bank byte |
| pbr | input | 8 | Program bank byte |
| pc | input | 16 | Program counter |
| emu | input | 1 | Emulation mode |
| xflag | input | 1 | Index width flag (1 = 8-bit) |
| mflag | input | 1 | Accumulator/memory width flag (1 = 8-bit) |
| ea_valid | output | 1 | Result valid, one cycle after request |
| ea | output | 24 | Address of first byte |
| ea_hi | output | 24 | Address of second byte |
| extra_cyc | output | 1 | Unaligned direct page penalty cycle |
| wide | output | 1 | Two-byte data access (one extra bus cycle) |

## Verification
The hardest cases to reach are the wrap boundaries. These are an absolute indexed sum whose offset carry must reach the bank byte, a direct page sum that must wrap inside bank zero, and the emulation page wrap, whose first or second byte must fall back to the start of the same page. Each is reached by loading the operand, base and index with values that sit just below a boundary, such as an offset of 0xFFF0 or an operand of 0xFE with an index of 1. The page wrap is also checked against an unaligned base one address away, which must not wrap and must raise the penalty flag.

// File: rtl/bea_pkg.sv
package bea_pkg;
  localparam int BANK_W = 8;
  localparam int OFF_W  = 16;
  localparam int ADDR_W = BANK_W + OFF_W;
  localparam int PAGE_W = OFF_W - BANK_W;

  typedef enum logic [2:0] {
    AM_ABS    = 3'd0,
    AM_ABSIDX = 3'd1,
    AM_LONG   = 3'd2,
    AM_DP     = 3'd3,
    AM_DPIDX  = 3'd4,
    AM_PROG   = 3'd5,
    AM_PTR    = 3'd6,
    AM_SPARE  = 3'd7
  } am_e;

  // bank:offset plus a zero-extended index, carried into the bank byte
  function automatic logic [ADDR_W-1:0] f_bank_add(
      input logic [BANK_W-1:0] bank,
      input logic [OFF_W-1:0]  off,
      input logic [OFF_W-1:0]  idx);
    return {bank, off} + {{BANK_W{1'b0}}, idx};
  endfunction

  // 16-bit offset sum; the carry out is dropped
  function automatic logic [OFF_W-1:0] f_off_sum(
      input logic [OFF_W-1:0] base,
      input logic [OFF_W-1:0] a,
      input logic [OFF_W-1:0] b);
    return base + a + b;
  endfunction

  // sum kept inside one 256-byte page
  function automatic logic [OFF_W-1:0] f_page_sum(
      input logic [PAGE_W-1:0] page,
      input logic [BANK_W-1:0] a,
      input logic [BANK_W-1:0] b);
    logic [BANK_W-1:0] low;
    low = a + b;
    return {page, low};
  endfunction
endpackage

// File: rtl/bea_index.sv
module bea_index
  import bea_pkg::*;
(
  input  logic [OFF_W-1:0] x_reg,
  input  logic [OFF_W-1:0] y_reg,
  input  logic             idx_sel,
  input  logic             narrow,
  output logic [OFF_W-1:0] idx
);
  logic [OFF_W-1:0] raw;
  assign raw = idx_sel ? y_reg : x_reg;

  for (genvar b = 0; b < OFF_W; b++) begin : g_bit
    if (b < BANK_W) begin : g_low
      assign idx[b] = raw[b];
    end else begin : g_high
      assign idx[b] = raw[b] & ~narrow;
    end
  end
endmodule

// File: rtl/bea_form.sv
module bea_form
  import bea_pkg::*;
(
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] opnd,
  input  logic [OFF_W-1:0]  idx,
  input  logic [OFF_W-1:0]  dpr,
  input  logic [BANK_W-1:0] dbr,
  input  logic [BANK_W-1:0] pbr,
  input  logic [OFF_W-1:0]  pc,
  input  logic              emu,
  input  logic              mflag,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] ea_hi,
  output logic              dp_slow,
  output logic              page_wrap,
  output logic              wide
);
  localparam logic [BANK_W-1:0] BANK0 = '0;
  localparam logic [OFF_W-1:0]  ONE16 = OFF_W'(1);

  logic              dp_aligned;
  logic [OFF_W-1:0]  dp_off;
  logic [OFF_W-1:0]  op8;

  assign dp_aligned = (dpr[BANK_W-1:0] == '0);
  assign op8        = {{PAGE_W{1'b0}}, opnd[BANK_W-1:0]};

  always_comb begin
    ea        = '0;
    ea_hi     = '0;
    dp_slow   = 1'b0;
    page_wrap = 1'b0;
    wide      = ~emu & ~mflag;
    dp_off    = '0;
    case (am_e'(mode))
      AM_ABSIDX: begin
        ea    = f_bank_add(dbr, opnd[OFF_W-1:0], idx);
        ea_hi = ea + ADDR_W'(1);
      end
      AM_LONG: begin
        ea    = opnd;
        ea_hi = ea + ADDR_W'(1);
      end
      AM_DP: begin
        dp_slow = ~dp_aligned;
        dp_off  = f_off_sum(dpr, op8, '0);
        ea      = {BANK0, dp_off};
        ea_hi   = {BANK0, dp_off + ONE16};
      end
      AM_DPIDX: begin
        dp_slow = ~dp_aligned;
        if (emu && dp_aligned) begin
          page_wrap = 1'b1;
          dp_off    = f_page_sum(dpr[OFF_W-1:BANK_W], opnd[BANK_W-1:0], idx[BANK_W-1:0]);
          ea        = {BANK0, dp_off};
          ea_hi     = {BANK0, f_page_sum(dp_off[OFF_W-1:BANK_W], dp_off[BANK_W-1:0], BANK_W'(1))};
        end else begin
          dp_off = f_off_sum(dpr, op8, idx);
          ea     = {BANK0, dp_off};
          ea_hi  = {BANK0, dp_off + ONE16};
        end
      end
      AM_PROG: begin
        wide  = 1'b0;
        ea    = {pbr, pc};
        ea_hi = {pbr, pc + ONE16};
      end
      AM_PTR: begin
        wide  = 1'b0;
        ea    = {BANK0, opnd[OFF_W-1:0]};
        ea_hi = {BANK0, opnd[OFF_W-1:0] + ONE16};
      end
      default: begin
        ea    = {dbr, opnd[OFF_W-1:0]};
        ea_hi = ea + ADDR_W'(1);
      end
    endcase
  end
endmodule

// File: rtl/bank_ea_gen.sv
module bank_ea_gen
  import bea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        mode,
  input  logic [23:0]       opnd,
  input  logic              idx_sel,
  input  logic [15:0]       x_reg,
  input  logic [15:0]       y_reg,
  input  logic [15:0]       dpr,
  input  logic [7:0]        dbr,
  input  logic [7:0]        pbr,
  input  logic [15:0]       pc,
  input  logic              emu,
  input  logic              xflag,
  input  logic              mflag,
  output logic              ea_valid,
  output logic [23:0]       ea,
  output logic [23:0]       ea_hi,
  output logic              extra_cyc,
  output logic              wide
);
  logic [OFF_W-1:0]  idx;
  logic [ADDR_W-1:0] ea_c, ea_hi_c;
  logic              dp_slow, page_wrap, wide_c;

  bea_index u_idx (
    .x_reg(x_reg), .y_reg(y_reg), .idx_sel(idx_sel),
    .narrow(emu | xflag), .idx(idx)
  );

  bea_form u_form (
    .mode(mode), .opnd(opnd), .idx(idx), .dpr(dpr), .dbr(dbr),
    .pbr(pbr), .pc(pc), .emu(emu), .mflag(mflag),
    .ea(ea_c), .ea_hi(ea_hi_c), .dp_slow(dp_slow),
    .page_wrap(page_wrap), .wide(wide_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_valid  <= 1'b0;
      ea        <= '0;
      ea_hi     <= '0;
      extra_cyc <= 1'b0;
      wide      <= 1'b0;
    end else begin
      ea_valid <= req_valid;
      if (req_valid) begin
        ea        <= ea_c;
        ea_hi     <= ea_hi_c;
        extra_cyc <= dp_slow;
        wide      <= wide_c;
      end
    end
  end
endmodule

// File: rtl/bea_chk.sv
module bea_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [2:0]  mode,
  input logic [23:0] opnd,
  input logic [15:0] dpr,
  input logic [7:0]  pbr,
  input logic [15:0] pc,
  input logic        emu,
  input logic        page_wrap,
  input logic        ea_valid,
  input logic [23:0] ea,
  input logic [23:0] ea_hi,
  input logic        extra_cyc,
  input logic        wide
);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> !ea_valid);

  assert_long_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && $past(mode) == 3'd2) |-> ea == $past(opnd));

  assert_dp_bank0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && ($past(mode) == 3'd3 || $past(mode) == 3'd4)) |-> ea[23:16] == 8'h00);

  assert_page_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && $past(page_wrap)) |-> (ea[15:8] == $past(dpr[15:8]) && ea_hi[15:8] == ea[15:8]));

  assert_penalty_dp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && extra_cyc) |->
      (($past(mode) == 3'd3 || $past(mode) == 3'd4) && $past(dpr[7:0]) != 8'h00));

  assert_prog_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && $past(mode) == 3'd5) |->
      (ea == {$past(pbr), $past(pc)} && ea_hi[23:16] == $past(pbr)));

  assert_ptr_bank0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && $past(mode) == 3'd6) |-> (ea[23:16] == 8'h00 && ea_hi[23:16] == 8'h00));

  assert_wide_native_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && wide) |-> !$past(emu));
endmodule

bind bank_ea_gen bea_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .opnd(opnd),
  .dpr(dpr), .pbr(pbr), .pc(pc), .emu(emu), .page_wrap(page_wrap),
  .ea_valid(ea_valid), .ea(ea), .ea_hi(ea_hi), .extra_cyc(extra_cyc), .wide(wide)
);

// File: tb/sim_bank_ea_gen.sv
module sim_bank_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic [23:0] opnd = '0;
  logic        idx_sel = 1'b0;
  logic [15:0] x_reg = '0, y_reg = '0, dpr = '0, pc = '0;
  logic [7:0]  dbr = '0, pbr = '0;
  logic        emu = 1'b1, xflag = 1'b1, mflag = 1'b1;
  logic        ea_valid, extra_cyc, wide;
  logic [23:0] ea, ea_hi;
  int ntests = 0, nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bank_ea_gen u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .opnd(opnd),
    .idx_sel(idx_sel), .x_reg(x_reg), .y_reg(y_reg), .dpr(dpr), .dbr(dbr),
    .pbr(pbr), .pc(pc), .emu(emu), .xflag(xflag), .mflag(mflag),
    .ea_valid(ea_valid), .ea(ea), .ea_hi(ea_hi), .extra_cyc(extra_cyc), .wide(wide)
  );

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %06h expected %06h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, capture at the rising edge, sample at the next fall
  task automatic fire();
    @(negedge clk) req_valid = 1'b1;
    @(negedge clk) req_valid = 1'b0;
  endtask

  task automatic expect_all(input string tag, input logic [23:0] e, input logic [23:0] eh,
                            input logic ex, input logic w);
    chk({tag, " ea_valid R1"}, {23'd0, ea_valid}, 24'd1);
    chk({tag, " ea"}, ea, e);
    chk({tag, " ea_hi R13"}, ea_hi, eh);
    chk({tag, " extra_cyc R9"}, {23'd0, extra_cyc}, {23'd0, ex});
    chk({tag, " wide R12"}, {23'd0, wide}, {23'd0, w});
  endtask

  task automatic t_reset();
    chk("R1 reset ea", ea, 24'h0);
    chk("R1 reset ea_hi", ea_hi, 24'h0);
    chk("R1 reset flags", {21'd0, ea_valid, extra_cyc, wide}, 24'h0);
  endtask

  task automatic t_abs();
    emu = 0; mflag = 0; xflag = 1;
    mode = 3'd0; dbr = 8'h12; opnd = 24'h993456; fire();
    expect_all("R2 abs", 24'h123456, 24'h123457, 1'b0, 1'b1);
    mode = 3'd7; dbr = 8'h40; opnd = 24'h00FFFF; fire();
    expect_all("R2 spare code", 24'h40FFFF, 24'h410000, 1'b0, 1'b1);
  endtask

  task automatic t_abs_idx();
    emu = 0; xflag = 0; mflag = 1;
    mode = 3'd1; dbr = 8'h12; opnd = 24'h00FFF0; idx_sel = 0; x_reg = 16'h0020; fire();
    expect_all("R3 bank carry", 24'h130010, 24'h130011, 1'b0, 1'b0);
    xflag = 1; idx_sel = 1; y_reg = 16'hAB05; dbr = 8'h01; opnd = 24'h002000; fire();
    expect_all("R4 narrow Y", 24'h012005, 24'h012006, 1'b0, 1'b0);
    xflag = 0; fire();
    expect_all("R4 full Y", 24'h01CB05, 24'h01CB06, 1'b0, 1'b0);
    emu = 1; fire();
    expect_all("R4 emu narrows", 24'h012005, 24'h012006, 1'b0, 1'b0);
  endtask

  task automatic t_long();
    emu = 0; mflag = 0; dbr = 8'h77; pbr = 8'h66;
    mode = 3'd2; opnd = 24'hFEDCBA; fire();
    expect_all("R5 long", 24'hFEDCBA, 24'hFEDCBB, 1'b0, 1'b1);
    opnd = 24'hFFFFFF; fire();
    expect_all("R5 long top", 24'hFFFFFF, 24'h000000, 1'b0, 1'b1);
  endtask

  task automatic t_dp();
    emu = 0; mflag = 1; dbr = 8'h55;
    mode = 3'd3; dpr = 16'h2000; opnd = 24'h000034; fire();
    expect_all("R6 dp aligned", 24'h002034, 24'h002035, 1'b0, 1'b0);
    dpr = 16'h20F0; fire();
    expect_all("R9 dp unaligned", 24'h002124, 24'h002125, 1'b1, 1'b0);
    dpr = 16'hFFF0; opnd = 24'h000020; fire();
    expect_all("R6 dp wrap", 24'h000010, 24'h000011, 1'b1, 1'b0);
    dpr = 16'hFF00; opnd = 24'h0000FF; fire();
    expect_all("R13 dp hi wrap", 24'h00FFFF, 24'h000000, 1'b0, 1'b0);
  endtask

  task automatic t_dp_idx();
    emu = 0; xflag = 0; mflag = 1; idx_sel = 0;
    mode = 3'd4; dpr = 16'h1000; opnd = 24'h000080; x_reg = 16'h0300; fire();
    expect_all("R7 dp idx native", 24'h001380, 24'h001381, 1'b0, 1'b0);
    emu = 1; dpr = 16'h0000; opnd = 24'h0000F0; x_reg = 16'h0025; fire();
    expect_all("R8 page wrap", 24'h000015, 24'h000016, 1'b0, 1'b0);
    dpr = 16'h0300; opnd = 24'h0000FE; x_reg = 16'h0001; fire();
    expect_all("R8 hi page wrap", 24'h0003FF, 24'h000300, 1'b0, 1'b0);
    dpr = 16'h0301; opnd = 24'h0000FF; x_reg = 16'h0001; fire();
    expect_all("R8 unaligned no wrap", 24'h000401, 24'h000402, 1'b1, 1'b0);
  endtask

  task automatic t_prog_ptr();
    emu = 0; mflag = 0; dbr = 8'h55;
    mode = 3'd5; pbr = 8'h7E; pc = 16'hFFFF; fire();
    expect_all("R10 prog", 24'h7EFFFF, 24'h7E0000, 1'b0, 1'b0);
    mode = 3'd6; opnd = 24'h33ABCD; fire();
    expect_all("R11 ptr", 24'h00ABCD, 24'h00ABCE, 1'b0, 1'b0);
    opnd = 24'h12FFFF; fire();
    expect_all("R11 ptr wrap", 24'h00FFFF, 24'h000000, 1'b0, 1'b0);
  endtask

  task automatic t_wide_idle();
    emu = 1; mflag = 0; mode = 3'd0; dbr = 8'h01; opnd = 24'h000010; fire();
    expect_all("R12 emu narrow", 24'h010010, 24'h010011, 1'b0, 1'b0);
    mode = 3'd3; dpr = 16'h0001; opnd = 24'h000001; emu = 0;
    @(negedge clk);
    chk("R1 idle no valid", {23'd0, ea_valid}, 24'd0);
    chk("R1 idle hold ea", ea, 24'h010010);
    chk("R1 idle hold flags", {22'd0, extra_cyc, wide}, 24'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_abs();
    t_abs_idx();
    t_long();
    t_dp();
    t_dp_idx();
    t_prog_ptr();
    t_wide_idle();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule